// File: doc/BRIEF.md
# Programmable Multi-Pattern Frame Matcher

This block watches received frames as they stream past as 32-bit dwords. It checks every frame against as many as eight patterns held in a 64-entry table of 40-bit words. Each pattern is a chain of table words. The chain starts where a pointer byte in one of the two header words says it starts. Each word in the chain can skip a few incoming dwords before it compares, can ignore chosen bytes, and can mark itself as the last word of its pattern.

All eight patterns are followed at the same time, one tracking lane per pattern. After the last dword of a frame, the block presents an 8-bit vector that shows which patterns matched. When any pattern matched, it also sets a sticky wake status flag. A wake output follows that flag while a wake enable input is high. The table is loaded through a plain synchronous write port.

Top module: `fpm_matcher`

## Requirements
- R1: After reset, res_valid, res_vec, wake_sts and wake_out are all 0.
- R2: Bit n of word 0 bits [7:0] enables pattern n. A pattern whose bit is 0 never sets its bit in res_vec.
- R3: Pattern k (k=0..3) starts at the word addressed by word 0 bits [8(k+1)+7:8(k+1)]. Pattern k (k=4..7) starts at the word addressed by word 1 bits [8(k-3)+7:8(k-3)]. A start pointer below 2 or at or above the table depth means that pattern never matches.
- R4: In a pattern word, bits [6:4] hold a skip count from 0 to 7. That many incoming dwords pass by before the word is compared with the next dword of the frame.
- R5: Bits [3:0] of a pattern word are byte masks. Pattern byte j sits in word bits [8j+15:8j+8] and is compared with frame bits [8j+7:8j] only when mask bit j is 1. A mask of 0 ignores the byte.
- R6: Comparison begins at the first dword of each frame. In the cycle after the dword that carries rx_last is accepted, res_valid is 1 for exactly one cycle. res_vec bit k is then 1 when every word of pattern k, up to and including the word with bit 7 set, compared equal.
- R7: A pattern does not match if the frame ends before its end word is compared. It also does not match if its chain runs past the last table word without reaching an end word.
- R8: wake_sts becomes 1 in the same cycle as a res_valid whose res_vec is non-zero. It stays 1 until a cycle with wake_clr high, and a new match wins over a clear in the same cycle.
- R9: wake_out is 1 exactly when wake_sts and wake_en are both 1.
- R10: Patterns are tracked independently. Several patterns may share table words and match in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 6 | Table word address |
| cfg_wdata | input | 40 | Table write data |
| rx_valid | input | 1 | Frame dword valid |
| rx_data | input | 32 | Frame dword, byte j in bits [8j+7:8j] |
| rx_last | input | 1 | Marks the last dword of a frame |
| wake_en | input | 1 | Lets wake_sts drive wake_out |
| wake_clr | input | 1 | Clears wake_sts |
| res_valid | output | 1 | One-cycle strobe for a frame result |
| res_vec | output | 8 | Per-pattern match vector |
| wake_sts | output | 1 | Sticky flag, set on any match |
| wake_out | output | 1 | Gated wake indication |

## Verification
Directed frames cover the cases one at a time. They compare an exact single-word pattern with its disabled copy, and a header-1 pointer with an out-of-range pointer. They put the target dword either at the skipped position or one dword early. They change a masked byte and then an unmasked one. They end a frame one dword short of an end word, and run a chain off the last table word. These pairs separate the pointer decode, the skip counting, the mask polarity and the end-of-frame cut-off. Seeded random rounds then build multi-word chains from the frame's own dwords, with random skips and masks, and flip single bits in some words. Several lanes therefore succeed or fail together, and each outcome is compared with a bench model that walks each chain by frame position. Wake checks cover sticky set, clear, no-match frames and enable gating.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int NPAT   = 8;
  localparam int WORD_W = 40;
  localparam int DAT_W  = 32;

  typedef struct packed {
    logic       eop;
    logic [2:0] skip;
    logic [3:0] mask;
  } ctrl_t;

  typedef enum logic [1:0] {L_IDLE, L_RUN, L_HIT, L_DEAD} lane_st_e;

  function automatic ctrl_t ctrl_of(input logic [WORD_W-1:0] w);
    return ctrl_t'(w[7:0]);
  endfunction

  function automatic logic [DAT_W-1:0] pat_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:8];
  endfunction

  // byte-wise compare, only bytes with a set mask bit count
  function automatic logic masked_eq(input logic [DAT_W-1:0] pat,
                                     input logic [DAT_W-1:0] dat,
                                     input logic [3:0] mask);
    logic ok;
    ok = 1'b1;
    for (int j = 0; j < 4; j++) begin
      if (mask[j] && (pat[8*j +: 8] != dat[8*j +: 8])) ok = 1'b0;
    end
    return ok;
  endfunction

  // start pointer byte of pattern k from the two header words
  function automatic logic [7:0] start_ptr(input logic [WORD_W-1:0] h0,
                                           input logic [WORD_W-1:0] h1,
                                           input int k);
    logic [7:0] p;
    if (k < 4) p = h0[8*(k+1) +: 8];
    else       p = h1[8*(k-3) +: 8];
    return p;
  endfunction

  function automatic logic ptr_ok(input logic [7:0] p, input int depth);
    return (p >= 8'd2) && (int'(p) < depth);
  endfunction
endpackage

// File: rtl/fpm_store.sv
module fpm_store
  import fpm_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int NRD   = 8
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]      raddr,
  output logic [NRD-1:0][WORD_W-1:0]  rdata,
  output logic [WORD_W-1:0]           hdr0,
  output logic [WORD_W-1:0]           hdr1
);
  // contents are not reset; software loads the table
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem_q[raddr[r]];
  end

  assign hdr0 = mem_q[0];
  assign hdr1 = mem_q[1];
endmodule

// File: rtl/fpm_lane.sv
module fpm_lane
  import fpm_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic              en_bit,
  input  logic [7:0]        start_byte,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [DAT_W-1:0]  dat,
  output logic              hit
);
  lane_st_e    st_q, st_d, st_e;
  logic [AW-1:0] ptr_q, ptr_d, ptr_e;
  logic [2:0]  skc_q, skc_d, skc_e;
  ctrl_t       ctl;
  logic        skip_now, cmp_now, eq, hit_now, last_word;

  // effective state: a new frame restarts the lane at its start pointer
  always_comb begin
    if (first) begin
      st_e  = (en_bit && ptr_ok(start_byte, DEPTH)) ? L_RUN : L_DEAD;
      ptr_e = start_byte[AW-1:0];
      skc_e = 3'd0;
    end else begin
      st_e  = st_q;
      ptr_e = ptr_q;
      skc_e = skc_q;
    end
  end

  assign rd_addr   = ptr_e;
  assign ctl       = ctrl_of(rd_word);
  assign skip_now  = (st_e == L_RUN) && (skc_e < ctl.skip);
  assign cmp_now   = (st_e == L_RUN) && !skip_now;
  assign eq        = masked_eq(pat_of(rd_word), dat, ctl.mask);
  assign hit_now   = beat && cmp_now && eq && ctl.eop;
  assign last_word = (ptr_e == AW'(DEPTH-1));
  assign hit       = (st_e == L_HIT) || hit_now;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    skc_d = skc_q;
    if (beat) begin
      st_d  = st_e;
      ptr_d = ptr_e;
      skc_d = skc_e;
      if (skip_now) begin
        skc_d = skc_e + 3'd1;
      end else if (cmp_now) begin
        if (!eq)            st_d = L_DEAD;
        else if (ctl.eop)   st_d = L_HIT;
        else if (last_word) st_d = L_DEAD;
        else begin
          ptr_d = ptr_e + AW'(1);
          skc_d = 3'd0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= L_IDLE;
      ptr_q <= '0;
      skc_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      skc_q <= skc_d;
    end
  end

  // R3: a running lane never points into the header words
  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_RUN) |-> (ptr_q >= AW'(2)));

  // R7: once matched, a lane keeps its result until the next frame starts
  a_r7_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !first && st_q == L_HIT) |=> (st_q == L_HIT));
endmodule

// File: rtl/fpm_wake.sv
module fpm_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic sts,
  output logic out
);
  logic sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sts_q <= 1'b0;
    else if (set)  sts_q <= 1'b1;
    else if (clr)  sts_q <= 1'b0;
  end

  assign sts = sts_q;
  assign out = sts_q & en;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !clr) |=> sts_q);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> sts_q);

  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    out |-> en);
endmodule

// File: rtl/fpm_matcher.sv
module fpm_matcher
  import fpm_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [39:0]       cfg_wdata,
  input  logic              rx_valid,
  input  logic [31:0]       rx_data,
  input  logic              rx_last,
  input  logic              wake_en,
  input  logic              wake_clr,
  output logic              res_valid,
  output logic [7:0]        res_vec,
  output logic              wake_sts,
  output logic              wake_out
);
  logic [NPAT-1:0][AW-1:0]     rd_addr;
  logic [NPAT-1:0][WORD_W-1:0] rd_word;
  logic [WORD_W-1:0]           hdr0, hdr1;
  logic [NPAT-1:0]             lane_hit;
  logic                        in_frame_q, frame_first, frame_end, wake_set;
  logic                        res_valid_q;
  logic [NPAT-1:0]             res_vec_q;

  assign frame_first = rx_valid && !in_frame_q;
  assign frame_end   = rx_valid && rx_last;
  assign wake_set    = frame_end && (lane_hit != '0);

  fpm_store #(.DEPTH(DEPTH), .AW(AW), .NRD(NPAT)) u_store (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .raddr (rd_addr),
    .rdata (rd_word),
    .hdr0  (hdr0),
    .hdr1  (hdr1)
  );

  for (genvar k = 0; k < NPAT; k++) begin : g_lane
    logic [7:0] sp;
    assign sp = start_ptr(hdr0, hdr1, k);
    fpm_lane #(.DEPTH(DEPTH), .AW(AW)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat       (rx_valid),
      .first      (frame_first),
      .en_bit     (hdr0[k]),
      .start_byte (sp),
      .rd_addr    (rd_addr[k]),
      .rd_word    (rd_word[k]),
      .dat        (rx_data),
      .hit        (lane_hit[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q  <= 1'b0;
      res_valid_q <= 1'b0;
      res_vec_q   <= '0;
    end else begin
      if (rx_valid) in_frame_q <= !rx_last;
      res_valid_q <= frame_end;
      if (frame_end) res_vec_q <= lane_hit;
    end
  end

  fpm_wake u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wake_set),
    .clr   (wake_clr),
    .en    (wake_en),
    .sts   (wake_sts),
    .out   (wake_out)
  );

  assign res_valid = res_valid_q;
  assign res_vec   = res_vec_q;

  // R6: a result strobe only ever follows an accepted last dword
  a_r6_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_q |-> $past(rx_valid && rx_last));

  // R8: a non-empty result always shows the wake flag alongside it
  a_r8_flag_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_q && res_vec_q != '0) |-> wake_sts);
endmodule

// File: tb/fpm_matcher_tb.sv
module fpm_matcher_tb;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [39:0] cfg_wdata = '0;
  logic rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic rx_last = 1'b0;
  logic wake_en = 1'b1;
  logic wake_clr = 1'b0;
  logic res_valid, wake_sts, wake_out;
  logic [7:0] res_vec;

  always #5 clk = ~clk;

  fpm_matcher #(.DEPTH(DEPTH)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .rx_valid, .rx_data,
    .rx_last, .wake_en, .wake_clr, .res_valid, .res_vec, .wake_sts, .wake_out
  );

  logic [39:0] mem [DEPTH];
  logic [31:0] frm [64];
  int checks = 0;
  int errors = 0;
  logic wk = 1'b0;
  logic [7:0] got;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // bench model: walk each chain by frame position
  function automatic logic [7:0] ref_vec(input int len);
    logic [7:0] v;
    v = '0;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] sp;
      int p, pos;
      bit done, ok, bad;
      sp = (k < 4) ? mem[0][8*(k+1) +: 8] : mem[1][8*(k-3) +: 8];
      ok = 0;
      done = !(mem[0][k] && sp >= 2 && int'(sp) < DEPTH);
      p = int'(sp);
      pos = 0;
      while (!done) begin
        pos += int'(mem[p][6:4]);
        if (pos >= len) done = 1;
        else begin
          bad = 0;
          for (int j = 0; j < 4; j++)
            if (mem[p][j] && mem[p][8*j+8 +: 8] != frm[pos][8*j +: 8]) bad = 1;
          if (bad) done = 1;
          else if (mem[p][7]) begin ok = 1; done = 1; end
          else begin
            pos++; p++;
            if (p >= DEPTH) done = 1;
          end
        end
      end
      v[k] = ok;
    end
    return v;
  endfunction

  task automatic wr(input int a, input logic [39:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    mem[a] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_hdr(input logic [7:0] en, input logic [63:0] ptrs);
    wr(0, {ptrs[31:0], en});
    wr(1, {ptrs[63:32], 8'h00});
  endtask

  task automatic send(input int len, input string tag);
    logic [7:0] e;
    e = ref_vec(len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = frm[i]; rx_last = (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    chk({tag, " R6 result strobe"}, 64'(res_valid), 64'd1);
    chk({tag, " R6 match vector vs model"}, 64'(res_vec), 64'(e));
    got = res_vec;
    if (e != 0) wk = 1'b1;
    chk({tag, " R8 wake status"}, 64'(wake_sts), 64'(wk));
    chk({tag, " R9 wake output"}, 64'(wake_out), 64'(wk & wake_en));
  endtask

  task automatic clear_wake();
    @(negedge clk); wake_clr = 1'b1;
    @(negedge clk); wake_clr = 1'b0;
    wk = 1'b0;
    chk("R8 cleared by wake_clr", 64'(wake_sts), 64'd0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pt;
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) frm[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 res_valid after reset", 64'(res_valid), 64'd0);
    chk("R1 res_vec after reset", 64'(res_vec), 64'd0);
    chk("R1 wake_sts after reset", 64'(wake_sts), 64'd0);
    chk("R1 wake_out after reset", 64'(wake_out), 64'd0);
    rst_n = 1'b1;
    for (int a = 0; a < DEPTH; a++) wr(a, 40'd0);

    // R2/R6: exact single-word pattern 0
    wr(2, {32'hA1B2C3D4, 8'h8F});
    pt = '0; pt[7:0] = 8'd2;
    set_hdr(8'h01, pt);
    frm[0] = 32'hA1B2C3D4; frm[1] = 32'h0;
    send(2, "R6 exact");
    chk("R6 exact pattern 0 matches", 64'(got), 64'h01);
    @(negedge clk);
    chk("R6 strobe lasts one cycle", 64'(res_valid), 64'd0);
    set_hdr(8'h00, pt);
    send(2, "R2 disabled");
    chk("R2 disabled pattern silent", 64'(got), 64'h00);

    // R3: header-1 pointer valid, pointer 1 invalid
    pt = '0; pt[15:8] = 8'd1; pt[47:40] = 8'd2;
    set_hdr(8'h22, pt);
    send(2, "R3 pointers");
    chk("R3 only pattern 5 matches", 64'(got), 64'h20);

    // R10: three patterns share one word
    pt = '0; pt[7:0] = 8'd2; pt[31:24] = 8'd2; pt[55:48] = 8'd2;
    set_hdr(8'h49, pt);
    send(2, "R10 shared");
    chk("R10 shared word matches three lanes", 64'(got), 64'h49);

    // R4: skip of two dwords
    wr(3, {32'h11223344, 8'hAF});
    pt = '0; pt[23:16] = 8'd3;
    set_hdr(8'h04, pt);
    frm[0] = 0; frm[1] = 0; frm[2] = 32'h11223344; frm[3] = 0;
    send(4, "R4 skip");
    chk("R4 skip 2 hits third dword", 64'(got), 64'h04);
    frm[1] = 32'h11223344; frm[2] = 0;
    send(4, "R4 early");
    chk("R4 target too early misses", 64'(got), 64'h00);

    // R5: mask 3 compares only pattern bytes 0 and 1
    wr(4, {32'hFFFF5566, 8'h83});
    pt = '0; pt[7:0] = 8'd4;
    set_hdr(8'h01, pt);
    frm[0] = 32'h00005566;
    send(1, "R5 masked");
    chk("R5 masked bytes ignored", 64'(got), 64'h01);
    frm[0] = 32'h00005567;
    send(1, "R5 unmasked");
    chk("R5 unmasked byte compared", 64'(got), 64'h00);

    // R7: frame ends before end word
    wr(5, {32'hCAFE0001, 8'h0F});
    wr(6, {32'hCAFE0002, 8'h8F});
    pt = '0; pt[39:32] = 8'd5;
    set_hdr(8'h10, pt);
    frm[0] = 32'hCAFE0001; frm[1] = 32'hCAFE0002;
    send(1, "R7 short");
    chk("R7 short frame misses", 64'(got), 64'h00);
    send(2, "R7 full");
    chk("R7 full chain matches", 64'(got), 64'h10);

    // R7: chain runs off the last table word; R9 gating with enable low
    wake_en = 1'b0;
    pt = '0; pt[63:56] = 8'd63;
    set_hdr(8'h80, pt);
    send(3, "R7 past end");
    chk("R7 chain past last word misses", 64'(got), 64'h00);
    chk("R9 wake_out low with enable low", 64'(wake_out), 64'd0);
    wake_en = 1'b1;
    clear_wake();
    send(3, "R8 no match");
    chk("R8 stays clear without match", 64'(wake_sts), 64'd0);

    // random rounds
    for (int it = 0; it < 40; it++) begin
      int len;
      logic [7:0] en;
      len = 3 + int'($urandom % 10);
      for (int i = 0; i < len; i++) frm[i] = $urandom;
      en = 8'($urandom);
      pt = '0;
      for (int k = 0; k < 8; k++) begin
        int base, nw, pos;
        base = 2 + 7 * k;
        pt[8*k +: 8] = 8'(base);
        nw = 1 + int'($urandom % 4);
        pos = 0;
        for (int w = 0; w < nw; w++) begin
          int sk;
          logic [3:0] mk;
          logic [31:0] d;
          sk = int'($urandom % 3);
          pos += sk;
          mk = 4'($urandom);
          d = (pos < len) ? frm[pos] : $urandom;
          if ($urandom % 4 == 0) d = d ^ (32'h1 << ($urandom % 32));
          wr(base + w, {d, (w == nw - 1), 3'(sk), mk});
          pos++;
        end
      end
      set_hdr(en, pt);
      wake_en = 1'($urandom);
      if (it % 10 == 9) clear_wake();
      send(len, "R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule